// File: doc/BRIEF.md
# I2C Controller Register Front End with Banked Window and Manual Clock Stall

This block sits between a byte-wide software register port and the rest of an I2C controller. A single five-bit offset space is shared by two register sets: the base configuration set and the FIFO-side control set. A select bit inside the main control register chooses which set answers at the offsets they have in common. A few offsets always reach the same register, whatever the selection.

Software can take direct control of the bus lines. Two level bits in the main control register drive open-drain outputs: a 0 pulls the line low and a 1 lets it float to the pull-up. Holding the clock low stalls the bus, for example while the receive threshold is being reprogrammed. The level bits are protected by a write-enable bit in a second control register. While that bit is clear, ordinary writes to the main control register change the bank and configuration bits but leave the line levels alone.

The protocol engine and the FIFO storage sit elsewhere. The FIFO-side registers here are plain byte stubs.

Top module: `i2c_reg_front`

## Requirements
- R1: After reset the following hold. Bank 0 is selected. The level write enable is clear. Both level bits are 1, so `scl_drive_low` and `sda_drive_low` are 0. Every stored register reads 0x00, except that offset 0x0E reads the sampled pins in bits 7:6.
- R2: Bit 5 of the control register at offset 0x0E selects the bank. At offsets 0x10, 0x1A, 0x1C and 0x1E, bank 0 and bank 1 reach separate registers that keep independent values. In bank 1 a write to 0x1A does not change the level write enable.
- R3: Offsets 0x0E, 0x18 and 0x19 reach the same register in both banks.
- R4: The level write enable is bit 7 of offset 0x1A in bank 0. While it is clear, a write to 0x0E leaves both level bits and both drive outputs unchanged, but still updates bits 5:0.
- R5: While the level write enable is set, a write to 0x0E loads bit 7 as the clock level and bit 6 as the data level. On the next cycle the matching drive output equals the inverse of the written bit (1 = pull low).
- R6: Reading 0x0E returns the pin inputs, passed through a two-stage synchronizer, in bit 7 (clock) and bit 6 (data). These bits do not return the stored level bits. A released line that another device holds low therefore reads 0.
- R7: Offsets that are not mapped in the current bank read 0x00. A write to such an offset changes no register.
- R8: Reserved bits read 0 and ignore writes. In bank 0, offset 0x1D stores only bit 4 (the FIFO enable) and offset 0x1A ignores bit 6. Bank-1-only offsets (0x12, 0x14) are unmapped in bank 0, and 0x1D is unmapped in bank 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |

## Verification
The hardest case to reach is one where the stored level and the observed pin disagree. This happens when software has released the clock but another device keeps it low. It also happens when an unprotected write carries level bits that must be discarded. The stimulus models the bus as a wired-AND: it lets an external holder pull either line low independently of the drive outputs, and it toggles the write enable and the bank bit at random between writes. Protected writes, unprotected writes, bank swaps and external holds therefore combine in every order.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;

  // offsets whose decode behaviour depends on the bank bit
  localparam logic [ADDR_W-1:0] OFS_CTL3     = 5'h0E;
  localparam logic [ADDR_W-1:0] OFS_LOW_A    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TXCTL    = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_TOUT     = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SHR_A    = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_SHR_B    = 5'h19;
  localparam logic [ADDR_W-1:0] OFS_CTL4     = 5'h1A;
  localparam logic [ADDR_W-1:0] OFS_HIGH_C   = 5'h1C;
  localparam logic [ADDR_W-1:0] OFS_FIFO_EN  = 5'h1D;
  localparam logic [ADDR_W-1:0] OFS_HIGH_E   = 5'h1E;

  localparam int CTL3_SCL_BIT  = 7;
  localparam int CTL3_SDA_BIT  = 6;
  localparam int CTL3_BANK_BIT = 5;
  localparam int CTL4_LWE_BIT  = 7;

  typedef enum logic [3:0] {
    RID_NONE, RID_CTL3, RID_SHR_A, RID_SHR_B, RID_OWN_ADDR, RID_CTL4,
    RID_FIFO_EN, RID_SCL_LO, RID_SCL_HI, RID_FIFO_CS, RID_TXF_CTL,
    RID_TOUT, RID_TXF_STS, RID_RXF_STS, RID_RXF_CTL
  } rid_e;

  localparam int NUM_RID = 15;

  function automatic rid_e decode_rid(input logic bank, input logic [ADDR_W-1:0] ofs);
    rid_e r;
    case (ofs)
      OFS_CTL3:    r = RID_CTL3;
      OFS_SHR_A:   r = RID_SHR_A;
      OFS_SHR_B:   r = RID_SHR_B;
      OFS_LOW_A:   r = bank ? RID_FIFO_CS : RID_OWN_ADDR;
      OFS_TXCTL:   r = bank ? RID_TXF_CTL : RID_NONE;
      OFS_TOUT:    r = bank ? RID_TOUT    : RID_NONE;
      OFS_CTL4:    r = bank ? RID_TXF_STS : RID_CTL4;
      OFS_HIGH_C:  r = bank ? RID_RXF_STS : RID_SCL_LO;
      OFS_FIFO_EN: r = bank ? RID_NONE    : RID_FIFO_EN;
      OFS_HIGH_E:  r = bank ? RID_RXF_CTL : RID_SCL_HI;
      default:     r = RID_NONE;
    endcase
    return r;
  endfunction

  // writable bits per register; level bits of CTL3 live in the override block
  function automatic logic [DATA_W-1:0] rid_wmask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      int'(RID_NONE):    m = 8'h00;
      int'(RID_CTL3):    m = 8'h3F;
      int'(RID_CTL4):    m = 8'hBF;
      int'(RID_FIFO_EN): m = 8'h10;
      default:           m = 8'hFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/i2cfe_bank_decode.sv
module i2cfe_bank_decode
  import i2cfe_pkg::*;
(
  input  logic              bank,
  input  logic [ADDR_W-1:0] ofs,
  output rid_e              rid
);
  always_comb rid = decode_rid(bank, ofs);
endmodule

// File: rtl/i2cfe_pin_sync.sv
module i2cfe_pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = pin_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end
    // idle lines float high, so the chain resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2cfe_regfile.sv
module i2cfe_regfile
  import i2cfe_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  rid_e                      wr_rid,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_RID*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_RID; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = rid_wmask(g);
    logic              hit;
    logic [DATA_W-1:0] q, d;

    always_comb begin
      hit = wr_en && (wr_rid == rid_e'(g));
      d   = (wdata & MASK) | (q & ~MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= d;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/i2cfe_line_override.sv
module i2cfe_line_override (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl3,
  input  logic       lvl_we,
  input  logic [1:0] wdata_lvl,   // [1]=clock level, [0]=data level
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  logic [1:0] lvl_q, lvl_d;
  logic       load;

  always_comb begin
    load  = wr_ctl3 && lvl_we;
    lvl_d = load ? wdata_lvl : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 2'b11;
    else        lvl_q <= lvl_d;
  end

  assign scl_drive_low = ~lvl_q[1];
  assign sda_drive_low = ~lvl_q[0];

  // R4: without the enable the drive outputs never move
  a_r4_lvl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_we |=> ($stable(scl_drive_low) && $stable(sda_drive_low)));

  // R5: an enabled write lands on the clock drive the next cycle
  a_r5_scl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl3 && lvl_we) |=> (scl_drive_low == !$past(wdata_lvl[1])));

  // R5: same for the data drive
  a_r5_sda_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl3 && lvl_we) |=> (sda_drive_low == !$past(wdata_lvl[0])));
endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2cfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [NUM_RID*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]         reg_arr [NUM_RID];
  for (genvar g = 0; g < NUM_RID; g++) begin : g_unpack
    assign reg_arr[g] = regs_flat[g*DATA_W +: DATA_W];
  end

  logic bank, lvl_we, wr_ctl3;
  rid_e rid;
  logic [1:0] pins_sync;

  assign bank   = reg_arr[RID_CTL3][CTL3_BANK_BIT];
  assign lvl_we = reg_arr[RID_CTL4][CTL4_LWE_BIT];

  i2cfe_bank_decode u_dec (
    .bank (bank),
    .ofs  (reg_addr),
    .rid  (rid)
  );

  assign wr_ctl3 = reg_wr && (rid == RID_CTL3);

  i2cfe_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr),
    .wr_rid    (rid),
    .wdata     (reg_wdata),
    .regs_flat (regs_flat)
  );

  i2cfe_line_override u_ovr (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_ctl3       (wr_ctl3),
    .lvl_we        (lvl_we),
    .wdata_lvl     ({reg_wdata[CTL3_SCL_BIT], reg_wdata[CTL3_SDA_BIT]}),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
  );

  i2cfe_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_i ({scl_in, sda_in}),
    .pin_o (pins_sync)
  );

  always_comb begin
    if (rid == RID_CTL3)
      reg_rdata = {pins_sync, reg_arr[RID_CTL3][CTL3_BANK_BIT:0]};
    else
      reg_rdata = reg_arr[rid];
  end

  // R2: in bank 1 the offset of the enable register reaches a FIFO stub
  a_r2_bank1_guard: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank && reg_wr && reg_addr == OFS_CTL4) |=> $stable(lvl_we));
endmodule

// File: tb/tb_i2c_reg_front.sv
`timescale 1ns/1ps
module tb_i2c_reg_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       scl_drive_low, sda_drive_low;
  logic       ext_scl_hold, ext_sda_hold;
  logic       scl_in, sda_in;

  always #2 clk = ~clk;   // 250 MHz

  assign scl_in = ~(scl_drive_low | ext_scl_hold);
  assign sda_in = ~(sda_drive_low | ext_sda_hold);

  i2c_reg_front dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_in),
    .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m0 [32];
  logic [7:0] m1 [32];
  logic m_scl, m_sda;

  function automatic logic [7:0] wmask(input logic bank, input logic [4:0] a);
    if (a == 5'h0E || a == 5'h18 || a == 5'h19) return 8'hFF;
    if (!bank) begin
      case (a)
        5'h10, 5'h1C, 5'h1E: return 8'hFF;
        5'h1A: return 8'hBF;
        5'h1D: return 8'h10;
        default: return 8'h00;
      endcase
    end else begin
      case (a)
        5'h10, 5'h12, 5'h14, 5'h1A, 5'h1C, 5'h1E: return 8'hFF;
        default: return 8'h00;
      endcase
    end
  endfunction

  function automatic logic cur_bank();
    return m0[5'h0E][5];
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    logic b = cur_bank();
    if (a == 5'h0E)
      return {m_scl & ~ext_scl_hold, m_sda & ~ext_sda_hold, m0[5'h0E][5:0]};
    if (wmask(b, a) == 8'h00) return 8'h00;
    if (a == 5'h18 || a == 5'h19 || !b) return m0[a];
    return m1[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic b = cur_bank();
    logic [7:0] mk = wmask(b, a);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 5'h0E) begin
      if (m0[5'h1A][7]) begin m_scl = d[7]; m_sda = d[6]; end
      m0[5'h0E] = {2'b00, d[5:0]};
    end else if (mk != 8'h00) begin
      if (a == 5'h18 || a == 5'h19 || !b) m0[a] = d & mk;
      else m1[a] = d & mk;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = exp_read(a);
    chk(reg_rdata === e, tag, reg_rdata, e);
  endtask

  task automatic chk_drive(input string tag);
    chk(scl_drive_low === ~m_scl, tag, {7'd0, scl_drive_low}, {7'd0, ~m_scl});
    chk(sda_drive_low === ~m_sda, tag, {7'd0, sda_drive_low}, {7'd0, ~m_sda});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] mapped [10] = '{5'h0E, 5'h10, 5'h12, 5'h14, 5'h18,
                                5'h19, 5'h1A, 5'h1C, 5'h1D, 5'h1E};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
    m_scl = 1'b1; m_sda = 1'b1;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ext_scl_hold = 0; ext_sda_hold = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    settle();

    // R1: reset state
    chk_drive("R1 reset drives");
    rd(5'h0E, "R1 ctl3 reset");
    rd(5'h1A, "R1 ctl4 reset");
    rd(5'h10, "R1 base reg reset");

    // R4: level bits locked while enable clear
    wr(5'h0E, 8'h15);
    chk_drive("R4 locked drives");
    rd(5'h0E, "R4 ctl3 low bits updated, levels kept");

    // R5: enabled writes
    wr(5'h1A, 8'h80);
    rd(5'h1A, "R5 enable readback");
    wr(5'h0E, 8'h40);
    chk_drive("R5 scl pulled low");
    rd(5'h0E, "R5/R6 pins reflect stall");
    wr(5'h0E, 8'h80);
    chk_drive("R5 sda pulled low");
    wr(5'h0E, 8'hC0);
    chk_drive("R5 release both");

    // R6: released line held by another device
    ext_scl_hold = 1; settle();
    rd(5'h0E, "R6 external clock hold reads 0");
    ext_scl_hold = 0; settle();
    rd(5'h0E, "R6 hold removed");

    // R4: lock again, try to stall
    wr(5'h1A, 8'h00);
    wr(5'h0E, 8'h00);
    chk_drive("R4 write ignored when locked");

    // R2/R3: banks
    wr(5'h10, 8'hA5);
    wr(5'h18, 8'h3C);
    wr(5'h0E, 8'h20);   // bank 1
    wr(5'h10, 8'h5A);
    wr(5'h1A, 8'hFF);   // TX status stub, not the enable
    wr(5'h19, 8'h99);
    rd(5'h10, "R2 bank1 0x10");
    rd(5'h1A, "R2 bank1 0x1A");
    rd(5'h18, "R3 shared 0x18 from bank1");
    rd(5'h1D, "R8 0x1D unmapped in bank1");
    wr(5'h0E, 8'hC0);   // enable clear, so levels stay
    chk_drive("R2 bank1 0x1A did not enable levels");
    wr(5'h0E, 8'h00);   // bank 0
    rd(5'h10, "R2 bank0 0x10 independent");
    rd(5'h1A, "R2 bank0 ctl4 untouched");
    rd(5'h19, "R3 shared 0x19 from bank0");

    // R7/R8
    wr(5'h11, 8'hEE);
    rd(5'h11, "R7 unmapped read zero");
    rd(5'h12, "R8 bank1-only offset unmapped in bank0");
    wr(5'h1D, 8'hFF);
    rd(5'h1D, "R8 fifo enable only bit4");
    wr(5'h1A, 8'h7F);
    rd(5'h1A, "R8 ctl4 bit6 reserved");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [4:0] a;
      logic [7:0] d;
      if ($urandom_range(0, 3) == 0) a = 5'($urandom_range(0, 31));
      else a = mapped[$urandom_range(0, 9)];
      d = 8'($urandom());
      if ($urandom_range(0, 7) == 0) begin
        ext_scl_hold = 1'($urandom()); ext_sda_hold = 1'($urandom());
      end
      wr(a, d);
      chk_drive("R4/R5 random drives");
      rd(5'($urandom_range(0, 31)), "R2/R3/R6/R7 random read");
      rd(a, "R2/R8 random readback");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule